// File: doc/BRIEF.md
# Channel Request Queue with Round-Robin Arbiter

This block sits between a group of host transfer channels and the transmit side of a host controller. Each channel that wants to post an IN token raises its request. A round-robin arbiter picks one eligible channel per cycle, and the grant writes an IN entry for that channel at the tail of a four-entry queue. The transmit side reads the head entry and pops it once the token has been handled.

When a channel reports that its final packet has arrived, its IN entries still waiting in the queue are removed in a single cycle. The other entries keep their order. The channel is then masked from arbitration, and a disable entry for it is appended as soon as the queue has room. When that disable entry reaches the head, the block pulses the channel's halted output for one cycle and drops the entry at the same clock edge. The transmit side never has to pop a disable entry. A halted channel rejoins arbitration when it is re-enabled.

Top module: `chq_req_queue`

## Requirements
- R1: After synchronous reset, the queue is empty, no grant is given, no halted output is high, every channel is eligible for arbitration, and the round-robin search starts at channel 0.
- R2: The queue holds at most 4 entries. No grant is given and no entry is written while 4 entries are held.
- R3: `grant_o` is zero or one-hot, and only goes to a requesting channel that is active and does not assert `last_i` in the same cycle. The search starts one channel past the last granted channel, wrapping from the highest channel to 0.
- R4: A grant to channel c appends an entry {channel c, IN} at the tail at the next clock edge, behind every entry already held.
- R5: When the head is an IN entry, `pop_i` removes it at the next edge. `pop_i` has no effect when the queue is empty or when the head is a disable entry.
- R6: `last_i[c]` on an active channel removes every IN entry of channel c at the next edge, keeping the order of the remaining entries. A head pop in the same cycle is applied as well.
- R7: After `last_i[c]` the channel receives no grant until it is re-enabled. Its disable entry is appended in a later cycle in which the queue holds fewer than 4 entries, and the lowest-numbered waiting channel goes first. No grant is given in a cycle where any disable entry is still waiting to be written.
- R8: `halted_o[c]` is high in exactly the cycle in which a disable entry for channel c is at the head, and that entry is removed at the following edge.
- R9: `enable_i[c]` returns a halted channel to arbitration. `enable_i` on a channel that is not halted, and `last_i` on a channel that is not active, have no effect.
- R10: `head_kind_o` encodes the head entry type: 0 for IN, 1 for disable. `head_ch_o` gives the channel number of the head entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 4 | Per-channel request to post an IN token |
| last_i | input | 4 | Per-channel final-packet indication (flush and disable) |
| enable_i | input | 4 | Per-channel re-enable of a halted channel |
| pop_i | input | 1 | Transmit side consumes the IN entry at the head |
| grant_o | output | 4 | One-hot grant; the granted channel's IN entry is written |
| head_valid_o | output | 1 | The queue holds at least one entry |
| head_ch_o | output | 2 | Channel number of the head entry |
| head_kind_o | output | 1 | Head entry type: 0 IN, 1 disable |
| halted_o | output | 4 | One-cycle per-channel halted pulse |

## Verification
The embedded assertions check, on every cycle, the properties that follow from the current state alone. The queue never holds more than four entries and is never written while full. A grant is one-hot and goes only to a requesting, active channel. A masked channel or one asserting its final-packet input is never granted. At most one halted pulse is high at a time, and a pulse comes only from a channel whose disable entry has already been written. The order-dependent behaviour can only be shown by the bench's scenarios, which run against a cycle-accurate reference model. That covers the fairness of the rotation, in-place removal that keeps the order of the survivors, the deferral of disable entries while the queue is full, the ignored pops on a disable head, and the re-enable path.

// File: rtl/chq_pkg.sv
package chq_pkg;
    localparam int NUM_CH = 4;
    localparam int DEPTH  = 4;
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef enum logic {
        KIND_IN  = 1'b0,
        KIND_DIS = 1'b1
    } kind_e;

    typedef struct packed {
        logic [CH_W-1:0] ch;
        kind_e           kind;
    } entry_t;

    typedef enum logic [1:0] {
        CH_ACTIVE = 2'd0,
        CH_DRAIN  = 2'd1,
        CH_HALTED = 2'd2
    } chst_e;

    function automatic logic [CH_W-1:0] lowest_set(input logic [NUM_CH-1:0] v);
        lowest_set = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (v[i]) lowest_set = CH_W'(i);
        end
    endfunction
endpackage

// File: rtl/chq_queue.sv
module chq_queue
    import chq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pop_head,
    input  logic [NUM_CH-1:0] flush_mask,
    input  logic              push,
    input  entry_t            push_entry,
    output entry_t            head,
    output logic              head_valid,
    output logic [CNT_W-1:0]  count
);
    entry_t           slot_q [DEPTH];
    entry_t           slot_d [DEPTH];
    logic [CNT_W-1:0] cnt_d;

    // remove popped head and flushed IN entries, compact, then append
    always_comb begin
        logic drop;
        cnt_d = '0;
        drop  = 1'b0;
        for (int i = 0; i < DEPTH; i++) slot_d[i] = '0;
        for (int i = 0; i < DEPTH; i++) begin
            drop = (i == 0 && pop_head) ||
                   (slot_q[i].kind == KIND_IN && flush_mask[slot_q[i].ch]);
            if (CNT_W'(i) < count && !drop) begin
                slot_d[cnt_d[IDX_W-1:0]] = slot_q[i];
                cnt_d = cnt_d + CNT_W'(1);
            end
        end
        if (push) begin
            slot_d[cnt_d[IDX_W-1:0]] = push_entry;
            cnt_d = cnt_d + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            count <= cnt_d;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
        end
    end

    assign head       = slot_q[0];
    assign head_valid = (count != '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)); // R2
    AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (rst)
        push |-> (count < CNT_W'(DEPTH))); // R2
    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (pop_head && !push) |=> (count < $past(count))); // R5
endmodule

// File: rtl/chq_rr_arb.sv
module chq_rr_arb
    import chq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] elig,
    input  logic              allow,
    output logic [NUM_CH-1:0] grant
);
    logic [CH_W-1:0] ptr_q;
    logic [CH_W-1:0] win;
    logic            found;

    always_comb begin
        grant = '0;
        found = 1'b0;
        win   = ptr_q;
        for (int k = 0; k < NUM_CH; k++) begin
            int idx;
            idx = (int'(ptr_q) + k) % NUM_CH;
            if (allow && !found && elig[idx]) begin
                found = 1'b1;
                win   = CH_W'(idx);
            end
        end
        if (found) grant[win] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (found) begin
            ptr_q <= (win == CH_W'(NUM_CH - 1)) ? '0 : win + CH_W'(1);
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R3
    AST_NO_GRANT_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        !allow |-> (grant == '0)); // R2
endmodule

// File: rtl/chq_chan_ctl.sv
module chq_chan_ctl
    import chq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic last_i,
    input  logic enable_i,
    input  logic push_ack,
    input  logic halt_seen,
    output logic active,
    output logic flush,
    output logic dis_pend
);
    chst_e st_q;
    logic  pend_q;

    assign active   = (st_q == CH_ACTIVE);
    assign flush    = active && last_i;
    assign dis_pend = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= CH_ACTIVE;
            pend_q <= 1'b0;
        end else begin
            case (st_q)
                CH_ACTIVE: begin
                    if (last_i) begin
                        st_q   <= CH_DRAIN;
                        pend_q <= 1'b1;
                    end
                end
                CH_DRAIN: begin
                    if (push_ack) pend_q <= 1'b0;
                    if (halt_seen) st_q <= CH_HALTED;
                end
                CH_HALTED: begin
                    if (enable_i) st_q <= CH_ACTIVE;
                end
                default: st_q <= CH_ACTIVE;
            endcase
        end
    end

    AST_HALT_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        halt_seen |-> (st_q == CH_DRAIN && !pend_q)); // R8
    AST_ACK_ONLY_PENDING: assert property (@(posedge clk) disable iff (rst)
        push_ack |-> pend_q); // R7
endmodule

// File: rtl/chq_req_queue.sv
module chq_req_queue
    import chq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] req_i,
    input  logic [NUM_CH-1:0] last_i,
    input  logic [NUM_CH-1:0] enable_i,
    input  logic              pop_i,
    output logic [NUM_CH-1:0] grant_o,
    output logic              head_valid_o,
    output logic [CH_W-1:0]   head_ch_o,
    output logic              head_kind_o,
    output logic [NUM_CH-1:0] halted_o
);
    logic [NUM_CH-1:0] active, flush, dis_pend, push_ack, elig;
    logic [CNT_W-1:0]  q_count;
    entry_t            head, push_entry;
    logic              head_valid, room, arb_allow, dis_push;
    logic              head_is_dis, pop_head, push;
    logic [CH_W-1:0]   dis_ch;

    assign room        = (q_count < CNT_W'(DEPTH));
    assign arb_allow   = room && (dis_pend == '0);
    assign elig        = req_i & active & ~last_i;
    assign dis_push    = room && (dis_pend != '0);
    assign dis_ch      = lowest_set(dis_pend);
    assign push_ack    = dis_push ? (NUM_CH'(1) << dis_ch) : '0;
    assign push        = dis_push || (grant_o != '0);
    assign head_is_dis = head_valid && (head.kind == KIND_DIS);
    assign pop_head    = head_valid && (head_is_dis || pop_i);

    always_comb begin
        if (dis_push) begin
            push_entry.ch   = dis_ch;
            push_entry.kind = KIND_DIS;
        end else begin
            push_entry.ch   = lowest_set(grant_o);
            push_entry.kind = KIND_IN;
        end
    end

    chq_rr_arb u_arb (
        .clk   (clk),
        .rst   (rst),
        .elig  (elig),
        .allow (arb_allow),
        .grant (grant_o)
    );

    chq_queue u_queue (
        .clk        (clk),
        .rst        (rst),
        .pop_head   (pop_head),
        .flush_mask (flush),
        .push       (push),
        .push_entry (push_entry),
        .head       (head),
        .head_valid (head_valid),
        .count      (q_count)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        assign halted_o[c] = head_is_dis && (head.ch == CH_W'(c));

        chq_chan_ctl u_ctl (
            .clk       (clk),
            .rst       (rst),
            .last_i    (last_i[c]),
            .enable_i  (enable_i[c]),
            .push_ack  (push_ack[c]),
            .halt_seen (halted_o[c]),
            .active    (active[c]),
            .flush     (flush[c]),
            .dis_pend  (dis_pend[c])
        );
    end

    assign head_valid_o = head_valid;
    assign head_ch_o    = head.ch;
    assign head_kind_o  = head.kind;

    AST_NO_GRANT_FULL: assert property (@(posedge clk) disable iff (rst)
        (q_count == CNT_W'(DEPTH)) |-> (grant_o == '0)); // R2
    AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (rst)
        (grant_o & ~req_i) == '0); // R3
    AST_MASKED_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        (grant_o & ~active) == '0); // R7
    AST_LAST_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        (grant_o & last_i) == '0); // R6
    AST_HALT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(halted_o)); // R8
endmodule

// File: tb/chq_req_queue_tb.sv
module chq_req_queue_tb;
    import chq_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NUM_CH-1:0] req_i = '0, last_i = '0, enable_i = '0;
    logic              pop_i = 1'b0;
    logic [NUM_CH-1:0] grant_o, halted_o;
    logic              head_valid_o, head_kind_o;
    logic [CH_W-1:0]   head_ch_o;

    always #10 clk = ~clk;

    chq_req_queue u_dut (
        .clk (clk), .rst (rst), .req_i (req_i), .last_i (last_i),
        .enable_i (enable_i), .pop_i (pop_i), .grant_o (grant_o),
        .head_valid_o (head_valid_o), .head_ch_o (head_ch_o),
        .head_kind_o (head_kind_o), .halted_o (halted_o)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    string tag = "R1";

    // reference model state
    int mq_ch[$];
    int mq_kind[$];
    int mst[NUM_CH];   // 0 active, 1 draining, 2 halted
    bit mpend[NUM_CH];
    int mrr;

    task automatic chk(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        int cnt, eg, exp_g, exp_h, dis_c;
        bit anyp;
        int nch[$];
        int nk[$];
        cnt = mq_ch.size(); eg = -1; exp_g = 0; exp_h = 0; dis_c = -1; anyp = 0;
        for (int c = 0; c < NUM_CH; c++) if (mpend[c]) anyp = 1;
        if (cnt < DEPTH && !anyp) begin
            for (int k = 0; k < NUM_CH; k++) begin
                int c;
                c = (mrr + k) % NUM_CH;
                if (eg < 0 && req_i[c] && mst[c] == 0 && !last_i[c]) eg = c;
            end
        end
        if (eg >= 0) exp_g = 1 << eg;
        chk("grant", int'(grant_o), exp_g);
        chk("head_valid", int'(head_valid_o), (cnt > 0) ? 1 : 0);
        if (cnt > 0) begin
            chk("head_ch", int'(head_ch_o), mq_ch[0]);
            chk("head_kind", int'(head_kind_o), mq_kind[0]);
            if (mq_kind[0] == 1) exp_h = 1 << mq_ch[0];
        end
        chk("halted", int'(halted_o), exp_h);

        for (int i = 0; i < cnt; i++) begin
            bit drop;
            drop = (i == 0 && (mq_kind[0] == 1 || pop_i)) ||
                   (mq_kind[i] == 0 && last_i[mq_ch[i]] && mst[mq_ch[i]] == 0);
            if (!drop) begin
                nch.push_back(mq_ch[i]);
                nk.push_back(mq_kind[i]);
            end
        end
        if (anyp && cnt < DEPTH) begin
            for (int c = NUM_CH - 1; c >= 0; c--) if (mpend[c]) dis_c = c;
            nch.push_back(dis_c); nk.push_back(1);
        end else if (eg >= 0) begin
            nch.push_back(eg); nk.push_back(0);
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (mst[c] == 0) begin
                if (last_i[c]) begin mst[c] = 1; mpend[c] = 1; end
            end else if (mst[c] == 1) begin
                if (c == dis_c) mpend[c] = 0;
                if (exp_h[c]) mst[c] = 2;
            end else if (enable_i[c]) begin
                mst[c] = 0;
            end
        end
        if (eg >= 0) mrr = (eg + 1) % NUM_CH;
        mq_ch = nch;
        mq_kind = nk;
    endtask

    task automatic step(input logic [NUM_CH-1:0] r, input logic [NUM_CH-1:0] l,
                        input logic [NUM_CH-1:0] e, input logic p);
        @(negedge clk);
        req_i = r; last_i = l; enable_i = e; pop_i = p;
        #1;
        model_step();
    endtask

    initial begin
        #(20 * 200000);
        n_fail++; n_checks++;
        $display("FAIL %s watchdog actual=timeout expected=finish", tag);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        bit [31:0] rs;
        rs = 32'h1BADF00D;
        for (int c = 0; c < NUM_CH; c++) begin mst[c] = 0; mpend[c] = 0; end
        mrr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        tag = "R1";  step(4'h0, 4'h0, 4'h0, 1'b0);            // empty after reset
        tag = "R3";  repeat (2) step(4'hF, 4'h0, 4'h0, 1'b0);  // rotation 0,1
        tag = "R4";  repeat (2) step(4'hF, 4'h0, 4'h0, 1'b0);  // tail writes 2,3
        tag = "R2";  repeat (2) step(4'hF, 4'h0, 4'h0, 1'b0);  // full: no grant
        tag = "R5";  repeat (2) step(4'h0, 4'h0, 4'h0, 1'b1);  // pops
        tag = "R3";  repeat (2) step(4'hF, 4'h0, 4'h0, 1'b0);  // wrap to 0,1
        tag = "R6";  step(4'h0, 4'h8, 4'h0, 1'b0);             // flush ch3 mid-queue
        tag = "R7";  step(4'hF, 4'h0, 4'h0, 1'b0);             // disable waits, no grant
                     step(4'h8, 4'h0, 4'h0, 1'b0);             // ch3 masked
        tag = "R9";  step(4'h0, 4'h8, 4'h0, 1'b0);             // last on non-active
        tag = "R8";  repeat (3) step(4'h0, 4'h0, 4'h0, 1'b1);
        tag = "R10"; step(4'h0, 4'h0, 4'h0, 1'b1);             // disable head, pop ignored (R5)
                     step(4'h0, 4'h0, 4'h0, 1'b0);
        tag = "R9";  step(4'h8, 4'h0, 4'h1, 1'b0);             // enable on active ignored
                     step(4'h0, 4'h0, 4'h8, 1'b0);             // re-enable ch3
                     step(4'h8, 4'h0, 4'h0, 1'b0);
        tag = "R6";  step(4'h0, 4'h8, 4'h0, 1'b1);             // pop and flush together

        tag = "R3";
        for (int n = 0; n < 3000; n++) begin
            logic [NUM_CH-1:0] l, e;
            rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
            l = (rs[19:16] == 4'h0) ? (NUM_CH'(1) << rs[5:4]) : '0;
            e = (rs[21:20] == 2'b00) ? rs[25:22] : '0;
            step(rs[3:0], l, e, rs[26] | rs[27]);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule